// File: doc/BRIEF.md
# Cascaded Baud Rate Divider

This block turns a fast reference clock into the two timing strobes a serial transmitter and receiver need. The first strobe is the oversampling tick. The second is the bit-period tick. Both are single-cycle clock enables in the reference clock domain, and no derived clocks are produced. An optional fixed divide-by-8 stage can slow the reference first. A 16-bit clock divisor then sets the oversampling tick, and an 8-bit bit divisor counts oversampling ticks to mark each bit period. The resulting bit rate is the selected clock divided by (clock divisor × (bit divisor + 1)).

Software supplies the prescale select and both divisors, and commits them with a single load strobe. A load restarts every counter in the chain, so the first period after a change is always a full one. Divisor values outside the legal range are handled in hardware. A clock divisor of 0 or 1 stops the generator. A bit divisor below 4 behaves as 4, and 255 behaves as 254.

Top module: `bdg_baud_gen`

## Requirements
- R1: After reset, and before any load, neither tick ever asserts (the clock divisor resets to 0).
- R2: With `cfg_prescale` = 0 and a clock divisor CD of 2 or more, `sample_tick` asserts once every CD cycles. Its first pulse falls in the CD-th cycle after the clock edge that samples `cfg_load`.
- R3: With `cfg_prescale` = 1, the reference is first divided by 8. `sample_tick` then asserts once every 8×CD cycles, and its first pulse falls in cycle 8×CD after the load edge.
- R4: A loaded clock divisor of 0 or 1 stops the generator: neither tick asserts until a later load.
- R5: `baud_tick` asserts only together with `sample_tick`, on every (BDIV+1)-th sample tick after a load, for a bit divisor BDIV from 4 to 254.
- R6: A bit divisor of 0, 1, 2 or 3 behaves exactly as a bit divisor of 4.
- R7: A bit divisor of 255 behaves exactly as a bit divisor of 254.
- R8: Neither tick asserts in a cycle where `cfg_load` is high. A load restarts all counters, so the first periods after a load are full length, whatever the previous count was.
- R9: Each tick is a one-cycle pulse; `sample_tick` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Commit strobe for the three configuration inputs; restarts all counters |
| cfg_prescale | input | 1 | 1 selects the reference divided by 8, 0 selects the reference directly |
| cfg_clk_div | input | 16 | Clock divisor CD (legal 2 to 65535) |
| cfg_bit_div | input | 8 | Bit divisor BDIV (legal 4 to 254) |
| sample_tick | output | 1 | One-cycle oversampling strobe |
| baud_tick | output | 1 | One-cycle bit-period strobe, coincident with a sample tick |

## Verification
The bench measures, from each load edge, the cycle of the first and second sample tick and of the first and second bit tick. It compares these against the rate formula over random prescale and divisor settings. Directed cases target the illegal divisors. A generator that counted with CD of 0 or 1 would emit a tick every cycle or wrap through the whole counter. A missing floor or ceiling on the bit divisor would produce bit periods of 1 to 4 or of 256 sample ticks. Back-to-back loads in mid-period catch a design that keeps its old count and emits a short first period, or that lets a stale tick through in the load cycle.

// File: rtl/bdg_pkg.sv
package bdg_pkg;
   // Smallest clock divisor that produces ticks
   localparam int CD_MIN = 2;
   // Smallest bit divisor honoured; lower values are raised to it
   localparam int BD_MIN = 4;
   // Fixed reference prescale ratio
   localparam int PRE_DIV_DEF = 8;

   typedef enum logic {
      REF_DIRECT = 1'b0,
      REF_SLOWED = 1'b1
   } ref_sel_e;
endpackage

// File: rtl/bdg_prescale.sv
module bdg_prescale #(
   parameter int PRE_DIV = bdg_pkg::PRE_DIV_DEF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic use_slow,
   output logic step_en
);
   generate
      if (PRE_DIV > 1) begin : g_div
         localparam int PW = $clog2(PRE_DIV);
         localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);
         logic [PW-1:0] pcnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pcnt <= '0;
            else if (restart || pcnt == LAST)
               pcnt <= '0;
            else
               pcnt <= pcnt + 1'b1;
         end

         assign step_en = use_slow ? (pcnt == LAST) : 1'b1;
      end else begin : g_pass
         assign step_en = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/bdg_sample_div.sv
module bdg_sample_div #(
   parameter int CD_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart,
   input  logic            step_en,
   input  logic [CD_W-1:0] divisor,
   output logic            tick
);
   localparam logic [CD_W-1:0] FLOOR = CD_W'(bdg_pkg::CD_MIN);

   logic [CD_W-1:0] scnt;
   logic            running;
   logic            wrap;

   assign running = (divisor >= FLOOR);
   assign wrap    = (scnt == divisor - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         scnt <= '0;
      else if (restart)
         scnt <= '0;
      else if (running && step_en)
         scnt <= wrap ? '0 : scnt + 1'b1;
   end

   assign tick = running & step_en & wrap & ~restart;
endmodule

// File: rtl/bdg_bit_div.sv
module bdg_bit_div #(
   parameter int BD_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart,
   input  logic            sample_in,
   input  logic [BD_W-1:0] divisor,
   output logic            tick
);
   localparam logic [BD_W-1:0] FLOOR = BD_W'(bdg_pkg::BD_MIN);
   localparam logic [BD_W-1:0] TOP   = {BD_W{1'b1}};
   localparam logic [BD_W-1:0] CEIL  = TOP - 1'b1;

   logic [BD_W-1:0] bcnt;
   logic [BD_W-1:0] eff;

   always_comb begin
      if (divisor < FLOOR)
         eff = FLOOR;
      else if (divisor == TOP)
         eff = CEIL;
      else
         eff = divisor;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bcnt <= '0;
      else if (restart)
         bcnt <= '0;
      else if (sample_in)
         bcnt <= (bcnt == eff) ? '0 : bcnt + 1'b1;
   end

   assign tick = sample_in & (bcnt == eff);
endmodule

// File: rtl/bdg_baud_gen.sv
module bdg_baud_gen #(
   parameter int CD_W    = 16,
   parameter int BD_W    = 8,
   parameter int PRE_DIV = bdg_pkg::PRE_DIV_DEF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_load,
   input  logic            cfg_prescale,
   input  logic [CD_W-1:0] cfg_clk_div,
   input  logic [BD_W-1:0] cfg_bit_div,
   output logic            sample_tick,
   output logic            baud_tick
);
   import bdg_pkg::*;

   initial begin
      assert (CD_W >= 2) else $error("CD_W too small");
      assert (BD_W >= 3) else $error("BD_W too small");
      assert (PRE_DIV >= 1 && (PRE_DIV & (PRE_DIV - 1)) == 0)
         else $error("PRE_DIV must be a power of two");
   end

   ref_sel_e        sel_q;
   logic [CD_W-1:0] cd_q;
   logic [BD_W-1:0] bd_q;
   logic            step_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= REF_DIRECT;
         cd_q  <= '0;
         bd_q  <= '0;
      end else if (cfg_load) begin
         sel_q <= ref_sel_e'(cfg_prescale);
         cd_q  <= cfg_clk_div;
         bd_q  <= cfg_bit_div;
      end
   end

   bdg_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (cfg_load),
      .use_slow (sel_q == REF_SLOWED),
      .step_en  (step_en)
   );

   bdg_sample_div #(.CD_W(CD_W)) u_sdiv (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (cfg_load),
      .step_en (step_en),
      .divisor (cd_q),
      .tick    (sample_tick)
   );

   bdg_bit_div #(.BD_W(BD_W)) u_bdiv (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (cfg_load),
      .sample_in (sample_tick),
      .divisor   (bd_q),
      .tick      (baud_tick)
   );
endmodule

// File: rtl/bdg_baud_gen_chk.sv
module bdg_baud_gen_chk #(
   parameter int CD_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            load,
   input logic            slow,
   input logic [CD_W-1:0] cd,
   input logic            sample_tick,
   input logic            baud_tick
);
   logic [3:0] since_baud;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         since_baud <= '0;
      else if (load || baud_tick)
         since_baud <= '0;
      else if (sample_tick && since_baud != 4'hF)
         since_baud <= since_baud + 1'b1;
   end

   // R5: a bit tick is always also a sample tick
   p_baud_on_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
      baud_tick |-> sample_tick);

   // R4: stopped generator emits nothing
   p_stopped_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cd < CD_W'(2)) |-> !sample_tick);

   // R8: no tick in a load cycle
   p_load_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (!sample_tick && !baud_tick));

   // R9: one-cycle pulses
   p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sample_tick |=> !sample_tick);

   // R3: slowed reference keeps ticks apart
   p_slow_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (slow && sample_tick) |=> !sample_tick);

   // R6: at least five sample ticks per bit period
   p_bit_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
      baud_tick |-> (since_baud >= 4'd4));
endmodule

bind bdg_baud_gen bdg_baud_gen_chk #(.CD_W(CD_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .load        (cfg_load),
   .slow        (sel_q == bdg_pkg::REF_SLOWED),
   .cd          (cd_q),
   .sample_tick (sample_tick),
   .baud_tick   (baud_tick)
);

// File: tb/test_bdg_baud_gen.sv
module test_bdg_baud_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_load = 1'b0;
   logic        cfg_prescale = 1'b0;
   logic [15:0] cfg_clk_div = '0;
   logic [7:0]  cfg_bit_div = '0;
   logic        sample_tick;
   logic        baud_tick;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   bdg_baud_gen i_bdg_baud_gen (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_load     (cfg_load),
      .cfg_prescale (cfg_prescale),
      .cfg_clk_div  (cfg_clk_div),
      .cfg_bit_div  (cfg_bit_div),
      .sample_tick  (sample_tick),
      .baud_tick    (baud_tick)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: actual=%0d cycles expected below 150000", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   function automatic int eff_bd(input int bd);
      if (bd < 4) return 4;
      if (bd == 255) return 254;
      return bd;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic run_cfg(input bit pre, input int cd, input int bd,
                          input string sreq, input string breq);
      int mult, sp, bp, limit;
      int fs, ss, fb, sb, ns, nb_first, consec, orphan;
      bit prev;
      mult = pre ? 8 : 1;
      sp = mult * cd;
      bp = sp * (eff_bd(bd) + 1);
      limit = (cd < 2) ? 200 : 2 * bp + 5;
      fs = -1; ss = -1; fb = -1; sb = -1; ns = 0; nb_first = -1;
      consec = 0; orphan = 0; prev = 1'b0;
      @(negedge clk);
      cfg_prescale = pre;
      cfg_clk_div = 16'(cd);
      cfg_bit_div = 8'(bd);
      cfg_load = 1'b1;
      #1;
      check(!sample_tick && !baud_tick, "R8", "tick during load",
            int'(sample_tick) + int'(baud_tick), 0);
      @(negedge clk);
      cfg_load = 1'b0;
      for (int c = 1; c <= limit; c++) begin
         #1;
         if (sample_tick) begin
            ns++;
            if (prev) consec++;
            if (fs < 0) fs = c; else if (ss < 0) ss = c;
         end
         if (baud_tick) begin
            if (!sample_tick) orphan++;
            if (fb < 0) begin fb = c; nb_first = ns; end
            else if (sb < 0) sb = c;
         end
         prev = sample_tick;
         @(negedge clk);
      end
      if (cd < 2) begin
         check(ns == 0 && fb < 0, "R4", "ticks with stopped divisor", ns, 0);
      end else begin
         check(fs == sp, sreq, "first sample tick cycle", fs, sp);
         check(ss - fs == sp, sreq, "sample period", ss - fs, sp);
         check(fb == bp, breq, "first bit tick cycle", fb, bp);
         check(sb - fb == bp, breq, "bit period", sb - fb, bp);
         check(nb_first == eff_bd(bd) + 1, breq, "sample ticks per bit",
               nb_first, eff_bd(bd) + 1);
         check(consec == 0, "R9", "back-to-back sample ticks", consec, 0);
         check(orphan == 0, "R5", "bit tick without sample tick", orphan, 0);
      end
   endtask

   initial begin
      int seed, q;
      seed = 32'h5eed;
      q = $urandom(seed);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: idle after reset
      begin
         int seen;
         seen = 0;
         for (int c = 0; c < 100; c++) begin
            @(negedge clk); #1;
            if (sample_tick || baud_tick) seen++;
         end
         check(seen == 0, "R1", "ticks before first load", seen, 0);
      end

      // Directed cases
      run_cfg(1'b0, 2, 4, "R2", "R5");
      run_cfg(1'b1, 3, 5, "R3", "R5");
      run_cfg(1'b0, 0, 6, "R4", "R4");
      run_cfg(1'b0, 1, 6, "R4", "R4");
      run_cfg(1'b0, 3, 0, "R2", "R6");
      run_cfg(1'b1, 2, 3, "R3", "R6");
      run_cfg(1'b0, 2, 255, "R2", "R7");
      run_cfg(1'b0, 2, 254, "R2", "R5");
      // R8: reload mid-period, then measure from the new load
      run_cfg(1'b0, 7, 4, "R8", "R8");
      @(negedge clk); cfg_clk_div = 16'd7; cfg_load = 1'b1;
      @(negedge clk); cfg_load = 1'b0;
      repeat (4) @(negedge clk);
      run_cfg(1'b0, 7, 4, "R8", "R8");
      run_cfg(1'b1, 5, 4, "R8", "R8");

      // Random mix
      for (int i = 0; i < 30; i++) begin
         bit pre;
         int cd, bd;
         pre = 1'($urandom_range(1, 0));
         cd = $urandom_range(12, 2);
         bd = $urandom_range(10, 0);
         run_cfg(pre, cd, bd, pre ? "R3" : "R2",
                 (bd < 4) ? "R6" : "R5");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule